// File: doc/BRIEF.md
# Cassette Transition-Window Bit Detector

This block turns the digitized output of a tape read comparator into serial data bits. Every level change on the tape input, rising or falling, becomes a one-cycle pulse. When no bit window is open, such a pulse opens a window. The window then counts timing ticks that arrive on a separate clock-enable input. If another transition shows up before the window has counted its full length, the bit is a 1. If the window runs out with no further transition, the bit is a 0.

Each decided bit is written into an output register. The register drives an asynchronous receiver's input line with inverted polarity, so a 0 bit and the reset state both give a high, idle line. A window-open flag is exported as a bit-rate square wave for clock recovery. A one-cycle strobe marks every newly latched bit.

The recovered data leaves as a plain serial level plus a strobe. There is no ready input and no back-pressure: a downstream consumer that misses a strobe loses that bit. The tick rate is chosen outside the block, for example by the tape speed setting.

Top module: `cas_bit_detector`

## Requirements
- R1: While reset is asserted and right after it is released, `uart_rx` is 1, `bit_vld` is 0 and `bit_clk` is 0.
- R2: `tape_in` passes through two synchronizer flops. A level change of either polarity, first sampled at rising edge k while no window is open, makes `bit_clk` go high after edge k+2.
- R3: A second transition that is taken in while the window is open, and not in its closing cycle, makes the decided bit 1. `uart_rx` then goes to 0.
- R4: A window that closes with no second transition decides a 0 bit, and `uart_rx` goes to 1.
- R5: The window closes at the clock edge that takes in the 12th asserted `win_tick` counted after the edge that opened it. At that edge `bit_clk` falls, and `uart_rx` takes its new value. `bit_vld` is 1 for exactly the cycle that follows.
- R6: Transitions after the second one inside the same window change neither the bit value nor the window length.
- R7: A transition taken in at the closing edge is ignored. It does not mark a 1 and does not open a new window.
- R8: `uart_rx` changes only together with a `bit_vld` pulse. Between bits it holds its value.
- R9: `win_tick` pulses that arrive while no window is open, or at the opening edge itself, are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tape_in | input | 1 | Comparator output, asynchronous to clk |
| win_tick | input | 1 | One-cycle clock enable at the window timing rate |
| uart_rx | output | 1 | Inverted recovered data for a serial receiver |
| bit_vld | output | 1 | One-cycle strobe when a new bit is latched |
| bit_clk | output | 1 | Window-open flag, toggles at the bit rate |

## Verification
A stuck or mis-counted window counter shows on `bit_clk` right away. The flag stays high longer or shorter than twelve ticks, so the error is visible within one window. A second-edge flag that is lost or not cleared shows on `uart_rx` at the next `bit_vld`, one bit period later at most. A spurious or missed edge pulse moves the rising edge of `bit_clk` by at least a cycle. Comparing all three outputs every clock against a behavioural model catches each of these at the first cycle where they differ.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_t;
endpackage

// File: rtl/cas_edge_sync.sv
module cas_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  // Either polarity gives a single-cycle pulse
  assign edge_pulse = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/cas_window.sv
module cas_window
  import cas_pkg::*;
#(
  parameter int WIN_COUNT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_pulse,
  input  logic tick,
  output logic win_open,
  output logic close_pulse,
  output logic close_bit
);
  localparam int CNT_W = (WIN_COUNT > 2) ? $clog2(WIN_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_COUNT - 1);

  win_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             second_q;

  assign close_pulse = (state_q == WIN_OPEN) && tick && (cnt_q == LAST);
  assign win_open    = (state_q == WIN_OPEN);
  assign close_bit   = second_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WIN_IDLE;
      cnt_q    <= '0;
      second_q <= 1'b0;
    end else if (state_q == WIN_IDLE) begin
      if (edge_pulse) begin
        state_q  <= WIN_OPEN;
        cnt_q    <= '0;
        second_q <= 1'b0;
      end
    end else if (close_pulse) begin
      state_q  <= WIN_IDLE;
      cnt_q    <= '0;
      second_q <= 1'b0;
    end else begin
      if (tick)       cnt_q    <= cnt_q + 1'b1;
      if (edge_pulse) second_q <= 1'b1;
    end
  end

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_IDLE && edge_pulse) |=> (state_q == WIN_OPEN));
  // R3
  second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_OPEN && edge_pulse && !close_pulse) |=> close_bit);
  // R7
  late_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_pulse && edge_pulse) |=> (state_q == WIN_IDLE));
endmodule

// File: rtl/cas_bit_reg.sv
module cas_bit_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic din,
  output logic bit_q,
  output logic vld_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= load;
      if (load) bit_q <= din;
    end
  end
endmodule

// File: rtl/cas_bit_detector.sv
module cas_bit_detector #(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_COUNT   = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tape_in,
  input  logic win_tick,
  output logic uart_rx,
  output logic bit_vld,
  output logic bit_clk
);
  logic edge_pulse;
  logic close_pulse;
  logic close_bit;
  logic data_bit;

  cas_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(tape_in), .edge_pulse(edge_pulse)
  );

  cas_window #(.WIN_COUNT(WIN_COUNT)) u_win (
    .clk(clk), .rst_n(rst_n), .edge_pulse(edge_pulse), .tick(win_tick),
    .win_open(bit_clk), .close_pulse(close_pulse), .close_bit(close_bit)
  );

  cas_bit_reg u_out (
    .clk(clk), .rst_n(rst_n), .load(close_pulse), .din(close_bit),
    .bit_q(data_bit), .vld_q(bit_vld)
  );

  assign uart_rx = ~data_bit;

  // R5
  vld_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $fell(bit_clk));
  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld);
  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |-> $stable(uart_rx));
endmodule

// File: tb/cas_bit_detector_tb_top.sv
module cas_bit_detector_tb_top;
  localparam int WIN = 12;
  localparam int SYN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tape_in = 1'b0;
  logic win_tick = 1'b0;
  logic uart_rx, bit_vld, bit_clk;

  int checks = 0;
  int fails = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  int vld_seen = 0;
  int last_rx = 1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cas_bit_detector dut_i (
    .clk(clk), .rst_n(rst_n), .tape_in(tape_in), .win_tick(win_tick),
    .uart_rx(uart_rx), .bit_vld(bit_vld), .bit_clk(bit_clk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int hist[$];
  int m_open, m_cnt, m_sec, m_bit, m_vld;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {0, 0, 0, 0};
      m_open = 0; m_cnt = 0; m_sec = 0; m_bit = 0; m_vld = 0;
    end else begin
      int e;
      hist.push_back(int'(tape_in));
      if (hist.size() > 8) void'(hist.pop_front());
      e = (hist[hist.size()-1-SYN] != hist[hist.size()-2-SYN]) ? 1 : 0;
      m_vld = 0;
      if (m_open == 0) begin
        if (e == 1) begin m_open = 1; m_cnt = 0; m_sec = 0; end
      end else if (win_tick && m_cnt == WIN - 1) begin
        m_bit = m_sec; m_vld = 1; m_open = 0; m_cnt = 0; m_sec = 0;
      end else begin
        if (win_tick) m_cnt++;
        if (e == 1) m_sec = 1;
      end
    end
  end

  // Tick generator
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
    win_tick = (tick_cnt == 0);
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(uart_rx == !m_bit[0], "R3/R4 uart_rx vs model", uart_rx, !m_bit[0]);
      chk(bit_vld == m_vld[0], "R5 bit_vld vs model", bit_vld, m_vld);
      chk(bit_clk == m_open[0], "R2 bit_clk vs model", bit_clk, m_open);
      if (bit_vld) begin vld_seen++; last_rx = uart_rx; end
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic flip();
    tape_in = ~tape_in;
  endtask

  initial begin
    #400_000_000;
    fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v0, hi;
    wait_n(3);
    // R1 reset state during reset
    chk(uart_rx == 1'b1, "R1 uart_rx in reset", uart_rx, 1);
    chk(bit_vld == 1'b0, "R1 bit_vld in reset", bit_vld, 0);
    chk(bit_clk == 1'b0, "R1 bit_clk in reset", bit_clk, 0);
    rst_n = 1'b1;
    wait_n(2);
    chk(uart_rx == 1'b1 && bit_clk == 1'b0, "R1 after release", bit_clk, 0);

    // R2 timing: rising change, opens after edge k+2
    tick_div = 1;
    wait_n(5);
    flip();                 // first sampled at edge k
    @(negedge clk);         // after k
    chk(bit_clk == 1'b0, "R2 not yet open after k", bit_clk, 0);
    @(negedge clk);         // after k+1
    chk(bit_clk == 1'b0, "R2 not yet open after k+1", bit_clk, 0);
    @(negedge clk);         // after k+2
    chk(bit_clk == 1'b1, "R2 open after k+2", bit_clk, 1);
    // R5/R9: window lasts exactly WIN ticks (tick every cycle)
    hi = 1;
    while (bit_clk && hi < 100) begin @(negedge clk); if (bit_clk) hi++; end
    chk(hi == WIN, "R5 window length in cycles", hi, WIN);
    chk(bit_vld == 1'b1, "R5 strobe after close", bit_vld, 1);
    // R4 zero bit
    chk(uart_rx == 1'b1, "R4 zero bit on uart_rx", uart_rx, 1);
    @(negedge clk);
    chk(bit_vld == 1'b0, "R5 strobe one cycle", bit_vld, 0);

    // R3 falling edge then second edge: one bit
    wait_n(4);
    flip();
    wait_n(5);
    flip();
    wait_n(20);
    chk(last_rx == 0, "R3 one bit on uart_rx", last_rx, 0);
    // R8 held between bits
    wait_n(10);
    chk(uart_rx == 1'b0, "R8 uart_rx held", uart_rx, 0);

    // R6 several extra edges in a window
    v0 = vld_seen;
    flip();
    wait_n(3); flip(); wait_n(2); flip(); wait_n(2); flip();
    wait_n(25);
    chk(vld_seen == v0 + 1, "R6 one bit per window", vld_seen, v0 + 1);
    chk(last_rx == 0, "R6 still one bit", last_rx, 0);

    // R7 edge in closing cycle is ignored
    v0 = vld_seen;
    flip();                 // sampled at k, opens at k+2, closes at k+14
    wait_n(WIN);
    flip();                 // sampled at k+12, taken in at k+14
    wait_n(30);
    chk(vld_seen == v0 + 1, "R7 no extra window", vld_seen, v0 + 1);
    chk(last_rx == 1, "R7 bit decided 0", last_rx, 1);
    chk(bit_clk == 1'b0, "R7 window stays closed", bit_clk, 0);

    // R9 ticks while idle do not shorten the next window (slow ticks)
    tick_div = 4;
    wait_n(40);
    flip();
    wait_n(3);
    hi = 0;
    while (bit_clk && hi < 500) begin @(negedge clk); hi++; end
    chk(hi >= 4 * (WIN - 1), "R9 full window with slow ticks", hi, 4 * WIN);

    // Mixed stream with random bits, compared every cycle to the model
    for (int b = 0; b < 300; b++) begin
      int one;
      one = $urandom_range(0, 1);
      flip();
      if (one == 1) begin wait_n(20); flip(); wait_n(40); end
      else wait_n(60);
    end
    tick_div = 3;
    for (int b = 0; b < 200; b++) begin
      flip();
      wait_n($urandom_range(1, 50));
    end
    wait_n(100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule